// File: doc/BRIEF.md
# Serial EEPROM Target with Region Write Protection

This block is a synthesizable SPI target (mode 0) that stands in for a 512-byte serial EEPROM. It samples the serial pins (chip select, serial clock, serial data in, pause and write-protect) with the system clock. It answers on a serial data output with a separate output-enable, which stands for the high-impedance state. Storage is an internal register array that resets to the erased value 0xFF.

The host reads any number of bytes from any address. It writes from one up to a full 16-byte page in one command. It reads and writes a small status register, and it sets or clears a write-enable latch. A write does not change the array right away. When chip select rises, a write cycle of `WR_CYCLES` system clocks begins, and the status busy bit stays set until the cycle ends. Writes are blocked by a two-bit region-protection code, by the write-enable latch and by the write-protect pin.

Top module: `spi_eeprom_tgt`

## Requirements
- R1: After reset the status register reads 0x00, the output enable is low and every array byte reads 0xFF.
- R2: READ is 0000_A011, where opcode bit 3 gives address bit 8 and the next byte gives bits 7..0. Data comes out MSB first, one byte per 8 clocks, with the address rising and wrapping from 0x1FF to 0x000 for as long as chip select stays low.
- R3: WREN (0x06) sets the write-enable bit (status bit 1) and WRDI (0x04) clears it. Each takes effect when chip select rises after a whole opcode.
- R4: WRITE (0000_A010) is ignored when the write-enable bit is clear. The array does not change and no write cycle begins.
- R5: Data bytes of an accepted WRITE wrap inside the 16-byte page. The page is committed only through a write cycle that starts when chip select rises on a byte boundary. While the cycle runs, status bit 0 reads 1. The write-enable bit clears when the cycle ends.
- R6: While a write cycle runs, every opcode except RDSR (0x05) is ignored.
- R7: Status bits 3:2 set the protected region: 00 none, 01 0x180–0x1FF, 10 0x100–0x1FF, 11 the whole array. A write to a protected page is dropped with no cycle, and the write-enable bit stays set.
- R8: With the write-protect pin low, no WRITE and no WRSR takes effect, whatever status bits 3:2 hold.
- R9: Pause low while the serial clock is low turns the output enable off and freezes the shift state until pause returns high. Serial clock edges in between are ignored.
- R10: WRSR (0x01) changes only status bits 3:2, through a write cycle. Status bits 7:4 always read 0.
- R11: The output enable is high only while chip select is low in the data phase of a READ or RDSR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data from host |
| hold_n | input | 1 | Transfer pause, active low |
| wp_n | input | 1 | Hardware write protect, active low |
| so | output | 1 | Serial data to host |
| so_oe | output | 1 | Drive enable for `so` (low means high impedance) |

## Verification
On every cycle the assertions check how the write-cycle timer relates to the command engine. A cycle begins only from a set write-enable latch, a high write-protect pin and a rising chip select. The protection bits stay put while a cycle runs, and the latch is clear when the cycle ends. No address or data phase overlaps a running cycle, and the shift state stays frozen under pause. Only the bench's scenarios can show what ends up in the array: a page wrapping within itself, a read running past the top of the array, and a write dropped by each protection code. The same holds for the byte values returned around a pause.

// File: rtl/eep_pkg.sv
package eep_pkg;

   typedef enum logic [2:0] {
      PH_OPC,    // collecting opcode
      PH_ADR,    // collecting low address byte
      PH_WDAT,   // collecting page data
      PH_RDAT,   // streaming array data
      PH_STAT,   // streaming status
      PH_SRD,    // collecting status write byte
      PH_SKIP    // frame ignored until chip select rises
   } phase_t;

   typedef enum logic [2:0] {
      CM_NONE,
      CM_WEN,
      CM_WDI,
      CM_WR,
      CM_WRSR
   } pend_t;

   localparam logic [7:0] OP_RDSR = 8'h05;
   localparam logic [7:0] OP_WRSR = 8'h01;
   localparam logic [7:0] OP_WREN = 8'h06;
   localparam logic [7:0] OP_WRDI = 8'h04;

   // top: the two most significant address bits of the page
   function automatic logic prot_hit(input logic [1:0] top, input logic [1:0] bp);
      logic hit;
      case (bp)
         2'b00:   hit = 1'b0;
         2'b01:   hit = top[1] & top[0];
         2'b10:   hit = top[1];
         default: hit = 1'b1;
      endcase
      return hit;
   endfunction

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
   parameter int         W      = 5,
   parameter int         STAGES = 2,
   parameter logic [W-1:0] RST  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 1) begin : g_one
         logic [W-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= {STAGES{RST}};
            else        r <= {r[STAGES-2:0], d};
         end
         assign q = r[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/eep_wtimer.sv
module eep_wtimer #(
   parameter int CYCLES = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);

   localparam int CW = $clog2(CYCLES + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt <= '0;
      else if (start && cnt == '0)   cnt <= CW'(CYCLES);
      else if (cnt != '0)            cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);
   assign done = (cnt == CW'(1));

endmodule

// File: rtl/eep_array.sv
module eep_array #(
   parameter int         ADDR_W = 9,
   parameter int         PAGE_W = 4,
   parameter logic [7:0] ERASED = 8'hFF,
   localparam int        PG     = 1 << PAGE_W,
   localparam int        PBW    = ADDR_W - PAGE_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   commit,
   input  logic [PBW-1:0]         pg_base,
   input  logic [PG-1:0][7:0]     pg_data,
   input  logic [PG-1:0]          pg_mask,
   input  logic [ADDR_W-1:0]      rd_addr,
   output logic [7:0]             rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
      end else if (commit) begin
         for (int j = 0; j < PG; j++)
            if (pg_mask[j]) mem[{pg_base, PAGE_W'(j)}] <= pg_data[j];
      end
   end

   assign rd_data = mem[rd_addr];

endmodule

// File: rtl/spi_eeprom_tgt.sv
module spi_eeprom_tgt
   import eep_pkg::*;
#(
   parameter int         ADDR_W      = 9,
   parameter int         PAGE_W      = 4,
   parameter int         WR_CYCLES   = 2000,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] ERASED      = 8'hFF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   input  logic si,
   input  logic hold_n,
   input  logic wp_n,
   output logic so,
   output logic so_oe
);

   localparam int PG  = 1 << PAGE_W;
   localparam int PBW = ADDR_W - PAGE_W;

   generate
      if (ADDR_W != 9) begin : g_bad_aw
         $error("ADDR_W must be 9: eight address bits plus one opcode bit");
      end
      if (PAGE_W < 1 || PAGE_W > 7) begin : g_bad_pw
         $error("PAGE_W must lie in 1..7");
      end
      if (WR_CYCLES < 1) begin : g_bad_wc
         $error("WR_CYCLES must be at least 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_ss
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   // synchronised pins
   logic cs_s, hold_s, wp_s, sck_s, si_s;

   eep_sync #(.W(5), .STAGES(SYNC_STAGES), .RST(5'b11100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, hold_n, wp_n, sck, si}),
      .q     ({cs_s, hold_s, wp_s, sck_s, si_s})
   );

   logic sck_q, cs_q, held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         cs_q  <= 1'b1;
         held  <= 1'b0;
      end else begin
         sck_q <= sck_s;
         cs_q  <= cs_s;
         if (cs_s)                  held <= 1'b0;
         else if (!hold_s && !sck_s) held <= 1'b1;
         else if (hold_s)           held <= 1'b0;
      end
   end

   logic sck_rise, sck_fall, cs_rise;
   assign sck_rise = ~cs_s & ~held &  sck_s & ~sck_q;
   assign sck_fall = ~cs_s & ~held & ~sck_s &  sck_q;
   assign cs_rise  =  cs_s & ~cs_q;

   // frame state
   phase_t              phase;
   pend_t               pend;
   logic [2:0]          bit_cnt;
   logic [6:0]          shreg;
   logic [ADDR_W-1:0]   addr;
   logic                is_rd;
   logic [7:0]          out_sh;
   logic                so_r;
   logic                wel;
   logic [1:0]          bp;
   logic [1:0]          sr_bp;
   logic [PBW-1:0]      pg_base;
   logic [PG-1:0][7:0]  pg_data;
   logic [PG-1:0]       pg_mask;
   logic [PAGE_W-1:0]   wr_off;
   logic                cyc_wr;

   logic                busy, cyc_done;
   logic [7:0]          byte_in, status, rd_data;
   logic                byte_done, whole, wr_prot;
   logic                start_wr, start_sr, cyc_start;
   logic [ADDR_W-1:0]   rd_addr;

   assign byte_in   = {shreg, si_s};
   assign byte_done = sck_rise && (bit_cnt == 3'd7);
   assign status    = {4'b0000, bp, wel, busy};
   assign whole     = cs_rise && (bit_cnt == 3'd0);
   assign wr_prot   = prot_hit(pg_base[PBW-1 -: 2], bp);
   assign start_wr  = whole && (pend == CM_WR) && wp_s && !wr_prot;
   assign start_sr  = whole && (pend == CM_WRSR) && wp_s;
   assign cyc_start = start_wr | start_sr;
   assign rd_addr   = (phase == PH_ADR) ? {addr[ADDR_W-1], byte_in} : addr + 1'b1;

   eep_wtimer #(.CYCLES(WR_CYCLES)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (cyc_start),
      .busy  (busy),
      .done  (cyc_done)
   );

   eep_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .ERASED(ERASED)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .commit  (cyc_done & cyc_wr),
      .pg_base (pg_base),
      .pg_data (pg_data),
      .pg_mask (pg_mask),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_OPC;
         pend    <= CM_NONE;
         bit_cnt <= '0;
         shreg   <= '0;
         addr    <= '0;
         is_rd   <= 1'b0;
         out_sh  <= '0;
         so_r    <= 1'b0;
         wel     <= 1'b0;
         bp      <= 2'b00;
         sr_bp   <= 2'b00;
         pg_base <= '0;
         pg_data <= '0;
         pg_mask <= '0;
         wr_off  <= '0;
         cyc_wr  <= 1'b0;
      end else begin
         if (cyc_start) cyc_wr <= start_wr;
         if (cs_s) begin
            phase   <= PH_OPC;
            pend    <= CM_NONE;
            bit_cnt <= '0;
            if (whole) begin
               case (pend)
                  CM_WEN:  wel <= 1'b1;
                  CM_WDI:  wel <= 1'b0;
                  CM_WRSR: if (wp_s) bp <= sr_bp;
                  default: ;
               endcase
            end
         end else if (sck_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
            shreg   <= byte_in[6:0];
            if (byte_done) begin
               case (phase)
                  PH_OPC: begin
                     if (busy && byte_in != OP_RDSR) begin
                        phase <= PH_SKIP;
                     end else if (byte_in == OP_RDSR) begin
                        phase  <= PH_STAT;
                        out_sh <= status;
                     end else if (byte_in == OP_WREN) begin
                        pend  <= CM_WEN;
                        phase <= PH_SKIP;
                     end else if (byte_in == OP_WRDI) begin
                        pend  <= CM_WDI;
                        phase <= PH_SKIP;
                     end else if (byte_in == OP_WRSR) begin
                        phase <= wel ? PH_SRD : PH_SKIP;
                     end else if (byte_in[7:4] == 4'h0 && byte_in[2:0] == 3'b011) begin
                        phase            <= PH_ADR;
                        is_rd            <= 1'b1;
                        addr[ADDR_W-1]   <= byte_in[3];
                     end else if (byte_in[7:4] == 4'h0 && byte_in[2:0] == 3'b010 && wel) begin
                        phase            <= PH_ADR;
                        is_rd            <= 1'b0;
                        addr[ADDR_W-1]   <= byte_in[3];
                        pg_mask          <= '0;
                     end else begin
                        phase <= PH_SKIP;
                     end
                  end
                  PH_ADR: begin
                     addr[7:0] <= byte_in;
                     if (is_rd) begin
                        phase  <= PH_RDAT;
                        out_sh <= rd_data;
                     end else begin
                        phase   <= PH_WDAT;
                        wr_off  <= byte_in[PAGE_W-1:0];
                        pg_base <= {addr[ADDR_W-1], byte_in[7:PAGE_W]};
                     end
                  end
                  PH_WDAT: begin
                     pg_data[wr_off] <= byte_in;
                     pg_mask[wr_off] <= 1'b1;
                     wr_off          <= wr_off + 1'b1;
                     pend            <= CM_WR;
                  end
                  PH_RDAT: begin
                     addr   <= rd_addr;
                     out_sh <= rd_data;
                  end
                  PH_STAT: out_sh <= status;
                  PH_SRD: begin
                     sr_bp <= byte_in[3:2];
                     pend  <= CM_WRSR;
                     phase <= PH_SKIP;
                  end
                  default: ;
               endcase
            end
         end else if (sck_fall) begin
            if (phase == PH_RDAT || phase == PH_STAT) begin
               so_r   <= out_sh[7];
               out_sh <= {out_sh[6:0], 1'b0};
            end
         end
         if (cyc_done) wel <= 1'b0;
      end
   end

   assign so    = so_r;
   assign so_oe = ~cs_s & ~held & (phase == PH_RDAT || phase == PH_STAT);

endmodule

// File: rtl/eep_chk.sv
module eep_chk
   import eep_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       cs_s,
   input logic       wp_s,
   input logic       held,
   input logic       busy,
   input logic       wel,
   input logic [1:0] bp,
   input phase_t     phase,
   input logic [2:0] bit_cnt,
   input logic [7:0] out_sh
);

   // R4
   cyc_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wel));

   // R8
   cyc_needs_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wp_s));

   // R5
   cyc_on_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cs_s));

   // R5
   wel_clear_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !wel);

   // R10
   bp_steady_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> $stable(bp));

   // R6
   no_access_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (phase != PH_ADR && phase != PH_WDAT && phase != PH_RDAT));

   // R9
   hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (held && !cs_s) |=> ($stable(bit_cnt) && $stable(out_sh)));

endmodule

bind spi_eeprom_tgt eep_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs_s    (cs_s),
   .wp_s    (wp_s),
   .held    (held),
   .busy    (busy),
   .wel     (wel),
   .bp      (bp),
   .phase   (phase),
   .bit_cnt (bit_cnt),
   .out_sh  (out_sh)
);

// File: tb/sim_spi_eeprom_tgt.sv
module sim_spi_eeprom_tgt;

   localparam int HALF = 5;
   localparam int WRC  = 600;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
   logic so, so_oe;

   always #2.5 clk = ~clk;

   spi_eeprom_tgt #(.WR_CYCLES(WRC)) u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
      .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe)
   );

   int n_cmp = 0, n_bad = 0;
   logic [7:0] mem_m [512];
   logic [1:0] bp_m = 2'b00;
   logic       wel_m = 1'b0;
   logic [7:0] wbuf [32];

   function automatic logic prot_m(input logic [8:0] a, input logic [1:0] b);
      case (b)
         2'b01:   return a >= 9'h180;
         2'b10:   return a >= 9'h100;
         2'b11:   return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [7:0] st_m();
      return {4'b0000, bp_m, wel_m, 1'b0};
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         si = tx[i];
         tick(HALF);
         rx[i] = so;
         sck = 1'b1;
         tick(HALF);
         sck = 1'b0;
      end
   endtask

   task automatic cs_lo();
      cs_n = 1'b0;
      tick(HALF);
   endtask

   task automatic cs_hi();
      tick(HALF);
      cs_n = 1'b1;
      tick(2 * HALF);
   endtask

   task automatic cmd1(input logic [7:0] op);
      logic [7:0] d;
      cs_lo(); xfer(op, d); cs_hi();
   endtask

   task automatic rdsr(output logic [7:0] s);
      logic [7:0] d;
      cs_lo(); xfer(8'h05, d); xfer(8'h00, s); cs_hi();
   endtask

   task automatic wait_ready();
      logic [7:0] s;
      for (int k = 0; k < 100; k++) begin
         rdsr(s);
         if (!s[0]) break;
      end
   endtask

   task automatic eep_read(input logic [8:0] a, input int len, input string tag);
      logic [7:0] d;
      logic [8:0] p;
      cs_lo();
      xfer({4'b0000, a[8], 3'b011}, d);
      xfer(a[7:0], d);
      for (int k = 0; k < len; k++) begin
         xfer(8'h00, d);
         p = a + 9'(k);
         check(tag, d, mem_m[p]);
      end
      cs_hi();
   endtask

   // wren, write len bytes of wbuf, settle, compare status
   task automatic eep_write(input logic [8:0] a, input int len, input string tag);
      logic [7:0] d, s;
      cmd1(8'h06);
      wel_m = 1'b1;
      cs_lo();
      xfer({4'b0000, a[8], 3'b010}, d);
      xfer(a[7:0], d);
      for (int k = 0; k < len; k++) xfer(wbuf[k], d);
      cs_hi();
      if (wp_n && !prot_m(a, bp_m) && len > 0) begin
         for (int k = 0; k < len; k++)
            mem_m[{a[8:4], 4'(int'(a[3:0]) + k)}] = wbuf[k];
         wait_ready();
         wel_m = 1'b0;
      end
      rdsr(s);
      check(tag, s, st_m());
      if (wel_m) begin
         cmd1(8'h04);
         wel_m = 1'b0;
      end
   endtask

   task automatic eep_wrsr(input logic [7:0] v, input string tag);
      logic [7:0] d, s;
      cmd1(8'h06);
      wel_m = 1'b1;
      cs_lo(); xfer(8'h01, d); xfer(v, d); cs_hi();
      if (wp_n) begin
         bp_m = v[3:2];
         wait_ready();
         wel_m = 1'b0;
      end
      rdsr(s);
      check(tag, s, st_m());
      if (wel_m) begin
         cmd1(8'h04);
         wel_m = 1'b0;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] s, d;
      logic [8:0] ra;
      int unsigned rv;
      for (int i = 0; i < 512; i++) mem_m[i] = 8'hFF;
      tick(4);
      rst_n = 1'b1;
      tick(4);

      // R1 reset state
      check("R1 so_oe idle", {7'b0, so_oe}, 8'h00);
      rdsr(s);
      check("R1 status", s, 8'h00);
      eep_read(9'h000, 2, "R1 erased");

      // R3 latch set and clear
      cmd1(8'h06);
      rdsr(s);
      check("R3 wren", s, 8'h02);
      cmd1(8'h04);
      rdsr(s);
      check("R3 wrdi", s, 8'h00);

      // R4 write without latch
      cs_lo(); xfer(8'h02, d); xfer(8'h10, d); xfer(8'h5A, d); cs_hi();
      rdsr(s);
      check("R4 no cycle", s, 8'h00);
      eep_read(9'h010, 1, "R4 unchanged");

      // R5 page wrap, R6 busy ignore
      for (int k = 0; k < 6; k++) wbuf[k] = 8'hA0 + 8'(k);
      cmd1(8'h06);
      cs_lo(); xfer(8'h0A, d); xfer(8'hFC, d);
      for (int k = 0; k < 6; k++) xfer(wbuf[k], d);
      cs_hi();
      for (int k = 0; k < 6; k++) mem_m[{5'h1F, 4'(12 + k)}] = wbuf[k];
      rdsr(s);
      check("R5 busy status", s, 8'h03);
      cmd1(8'h04);
      rdsr(s);
      check("R6 wrdi ignored while busy", s, 8'h03);
      wait_ready();
      rdsr(s);
      check("R5 wel cleared", s, 8'h00);
      eep_read(9'h1F0, 16, "R5 page wrap");
      eep_read(9'h1FE, 4, "R2 array wrap");

      // R10 status write masks
      eep_wrsr(8'hFF, "R10 wrsr");
      // R7 each protection code
      for (int b = 0; b < 4; b++) begin
         eep_wrsr(8'(b << 2), "R7 set bp");
         wbuf[0] = 8'h30 + 8'(b);
         eep_write(9'h17F, 1, "R7 status");
         eep_read(9'h17F, 1, "R7 0x17F");
         wbuf[0] = 8'h40 + 8'(b);
         eep_write(9'h180, 1, "R7 status");
         eep_read(9'h180, 1, "R7 0x180");
         wbuf[0] = 8'h50 + 8'(b);
         eep_write(9'h0FF, 1, "R7 status");
         eep_read(9'h0FF, 1, "R7 0x0FF");
         wbuf[0] = 8'h60 + 8'(b);
         eep_write(9'h100, 1, "R7 status");
         eep_read(9'h100, 1, "R7 0x100");
      end
      eep_wrsr(8'h00, "R10 clear bp");

      // R8 pin protect
      wp_n = 1'b0;
      wbuf[0] = 8'h77;
      eep_write(9'h020, 1, "R8 write blocked");
      eep_read(9'h020, 1, "R8 array kept");
      eep_wrsr(8'h0C, "R8 wrsr blocked");
      wp_n = 1'b1;

      // R9 pause during a read, R11 output enable
      cs_lo();
      xfer(8'h0B, d);
      xfer(8'hF0, d);
      check("R11 oe in read", {7'b0, so_oe}, 8'h01);
      xfer(8'h00, d);
      check("R9 byte before", d, mem_m[9'h1F0]);
      hold_n = 1'b0;
      tick(2 * HALF);
      check("R9 oe off", {7'b0, so_oe}, 8'h00);
      for (int k = 0; k < 3; k++) begin
         si = k[0];
         sck = 1'b1; tick(HALF);
         sck = 1'b0; tick(HALF);
      end
      hold_n = 1'b1;
      tick(2 * HALF);
      check("R9 oe back", {7'b0, so_oe}, 8'h01);
      xfer(8'h00, d);
      check("R9 byte after", d, mem_m[9'h1F1]);
      cs_hi();
      check("R11 oe off after cs", {7'b0, so_oe}, 8'h00);

      // random mix, R2 and R5
      rv = $urandom(32'h5EED_0042);
      for (int it = 0; it < 30; it++) begin
         ra = 9'($urandom % 512);
         if ($urandom % 2 == 0) begin
            int n;
            n = 1 + int'($urandom % 18);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            eep_write(ra, n, "R5 random write");
         end else begin
            eep_read(ra, 1 + int'($urandom % 6), "R2 random read");
         end
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule